// File: doc/BRIEF.md
# Self-Clocked Serial Converter Receiver

This block is the host side of a serial link to a sampling converter that sends no clock back. It starts a conversion with a one-cycle pulse and waits a fixed number of host cycles for the conversion to finish. It then drives a burst of serial clock pulses and rebuilds a 16-bit two's-complement sample from the returned data line. The serial clock rests high. Each burst period is a whole number of host cycles. The clock is low for one host cycle at the start of each period and high for the rest.

The link gives no frame or chip-select signal, so the word boundary comes from a two-bit marker that comes before the data. The marker is a one followed by a zero. The data line is sampled once per host cycle, which gives NPH sampling phases per burst period. A decision loop runs once per burst period. It finds the first phase in which the marker's one appears, locks onto that phase, and reads the marker's zero and all data bits in the same phase of the following periods. The board delay of the data line can therefore be any whole number of host cycles, as long as the marker's one still appears within the burst. A frame with a missing or damaged marker gives an error pulse instead of a sample.

The start period, the conversion latency, the number of phases and the word width are all parameters, counted in host clock cycles.

Top module: `adc_selfclk_rx`

## Requirements
- R1: While `en` is high, `conv_start` pulses high for exactly one host cycle every CYC_CYCLES cycles. Enable is sampled at each period boundary, and a period that begins with `en` low gives no pulse and no burst.
- R2: `sclk` is high except during a burst. The first low cycle comes exactly LAT_CYCLES cycles after the cycle in which `conv_start` is high. A burst has exactly NBITS+2 low cycles. Each low cycle is one host cycle, and consecutive low cycles are NPH cycles apart.
- R3: The receiver locks to the first sampling phase in which the data line reads 1 after the burst begins, and it tolerates any data-line delay of whole host cycles for which that 1 still appears within the burst.
- R4: After the marker, the next NBITS bits are assembled most significant bit first into `sample`, unchanged as a two's-complement word. For example, a received 1 then fifteen 0s gives 16'h8000.
- R5: `sample_vld` is high for one host cycle per good frame. If the marker's 1 first appears in burst period h (counting from 0), the strobe comes LAT_CYCLES + 1 + NPH*(h + 2 + NBITS) cycles after the `conv_start` cycle.
- R6: If the bit after the marker's 1, read in the locked phase, is also 1, `sync_err` pulses for one cycle LAT_CYCLES + 1 + NPH*(h + 2) cycles after `conv_start`, and no strobe is given for that frame.
- R7: If the data line reads 0 throughout the NBITS+2 burst periods, `sync_err` pulses for one cycle LAT_CYCLES + 1 + NPH*(NBITS + 2) cycles after `conv_start`, and no strobe is given for that frame.
- R8: `sample` changes only in a cycle where `sample_vld` is high. After an error frame it still holds the last good word.
- R9: During reset, `conv_start` is 0, `sclk` is 1, `sample_vld` and `sync_err` are 0, and `sample` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low reset |
| en | input | 1 | Allows conversions to be issued |
| din | input | 1 | Serial data line from the converter |
| conv_start | output | 1 | One-cycle conversion start pulse |
| sclk | output | 1 | Burst clock to the converter, idles high |
| sample | output | NBITS | Last received two's-complement word |
| sample_vld | output | 1 | One-cycle strobe when `sample` updates |
| sync_err | output | 1 | One-cycle pulse for a frame with no valid marker |

## Verification
If the locked phase is wrong, every data bit is still read in the same off-centre phase. Frames with a delay that moves the marker into another phase then come out shifted by one bit, or arrive one burst period late. The bench sees this at the first frame after a delay change, both in the sample value and in the exact strobe cycle. If the hunt or marker state is wrong, a damaged frame still produces a sample, or a good frame produces an error pulse. Both are seen within the same conversion period, because each frame's result is compared before the next start pulse.

// File: rtl/adc_sc_pkg.sv
package adc_sc_pkg;

  typedef enum logic [1:0] {
    RX_OFF,
    RX_HUNT,
    RX_HDR,
    RX_DATA
  } rx_state_t;

  // host cycles occupied by one burst of serial clock pulses
  function automatic int burst_cycles(input int nph, input int npulse);
    return nph * npulse;
  endfunction

  // cycles from the start pulse to the result strobe when the
  // marker's one is found in burst period hdr_period
  function automatic int result_offset(input int lat, input int nph,
                                       input int hdr_period, input int nbits);
    return lat + 1 + nph * (hdr_period + 2 + nbits);
  endfunction

endpackage

// File: rtl/adc_sc_seq.sv
module adc_sc_seq
  import adc_sc_pkg::*;
#(
  parameter int CYC_CYCLES = 120,
  parameter int LAT_CYCLES = 8,
  parameter int NPH        = 3,
  parameter int NPULSE     = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic conv_o,
  output logic sclk_o,
  output logic go_o
);

  localparam int CW    = $clog2(CYC_CYCLES);
  localparam int PW    = (NPH > 1) ? $clog2(NPH) : 1;
  localparam int BURST = burst_cycles(NPH, NPULSE);

  logic [CW-1:0] cnt;
  logic [PW-1:0] bph;
  logic          live;
  logic          burst_on;
  logic          wrap;

  assign wrap     = (cnt == CW'(CYC_CYCLES - 1));
  assign burst_on = live && (cnt >= CW'(LAT_CYCLES)) &&
                    (cnt < CW'(LAT_CYCLES + BURST));

  // free-running period counter, enable taken at the boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      live <= 1'b0;
    end else begin
      cnt <= wrap ? '0 : cnt + 1'b1;
      if (cnt == '0) live <= en;
    end
  end

  // phase of the burst clock within one period
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bph <= '0;
    end else if (burst_on) begin
      bph <= (bph == PW'(NPH - 1)) ? '0 : bph + 1'b1;
    end else begin
      bph <= '0;
    end
  end

  // registered outputs, all delayed by one cycle alike
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_o <= 1'b0;
      sclk_o <= 1'b1;
      go_o   <= 1'b0;
    end else begin
      conv_o <= (cnt == '0) && en;
      sclk_o <= !(burst_on && (bph == '0));
      go_o   <= live && (cnt == CW'(LAT_CYCLES));
    end
  end

endmodule

// File: rtl/adc_sc_align.sv
module adc_sc_align
  import adc_sc_pkg::*;
#(
  parameter int NPH    = 3,
  parameter int NBITS  = 16,
  parameter int NPULSE = 18,
  localparam int PW    = (NPH > 1) ? $clog2(NPH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          din,
  output logic          period_end,
  output logic          lock_evt,
  output logic [PW-1:0] lock_ph,
  output logic          bit_stb,
  output logic          bit_val,
  output logic          bit_last,
  output logic          sync_err
);

  localparam int PCW = $clog2(NPULSE + 1);
  localparam int BCW = $clog2(NBITS + 1);

  rx_state_t      st;
  logic           din_q;
  logic [PW-1:0]  rph;
  logic [NPH-1:0] samp;
  logic [NPH-1:0] cur_vec;
  logic [PCW-1:0] pc;
  logic [BCW-1:0] bc;
  logic           hit;
  logic [PW-1:0]  hit_idx;
  logic           hunt_to;
  logic           hdr_bad;

  // one register on the incoming line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) din_q <= 1'b0;
    else        din_q <= din;
  end

  // samples of the current period, last phase taken live
  always_comb begin
    for (int i = 0; i < NPH; i++) begin
      cur_vec[i] = (i == NPH - 1) ? din_q : samp[i];
    end
  end

  // earliest phase holding a one
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = NPH - 1; i >= 0; i--) begin
      if (cur_vec[i]) begin
        hit     = 1'b1;
        hit_idx = PW'(i);
      end
    end
  end

  assign period_end = (st != RX_OFF) && (rph == PW'(NPH - 1));
  assign lock_evt   = period_end && (st == RX_HUNT) && hit;
  assign bit_val    = cur_vec[lock_ph];
  assign bit_stb    = period_end && (st == RX_DATA);
  assign bit_last   = bit_stb && (bc == BCW'(NBITS - 1));
  assign hunt_to    = period_end && (st == RX_HUNT) && !hit &&
                      (pc == PCW'(NPULSE - 1));
  assign hdr_bad    = period_end && (st == RX_HDR) && bit_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= RX_OFF;
      rph     <= '0;
      samp    <= '0;
      pc      <= '0;
      bc      <= '0;
      lock_ph <= '0;
    end else if (go) begin
      st  <= RX_HUNT;
      rph <= '0;
      pc  <= '0;
      bc  <= '0;
    end else if (st != RX_OFF) begin
      samp[rph] <= din_q;
      rph       <= (rph == PW'(NPH - 1)) ? '0 : rph + 1'b1;
      if (period_end) begin
        case (st)
          RX_HUNT: begin
            if (hit) begin
              lock_ph <= hit_idx;
              st      <= RX_HDR;
            end else begin
              pc <= pc + 1'b1;
              if (hunt_to) st <= RX_OFF;
            end
          end
          RX_HDR:  st <= bit_val ? RX_OFF : RX_DATA;
          RX_DATA: begin
            bc <= bc + 1'b1;
            if (bit_last) st <= RX_OFF;
          end
          default: st <= RX_OFF;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_err <= 1'b0;
    else        sync_err <= hunt_to || hdr_bad;
  end

endmodule

// File: rtl/adc_sc_deser.sv
module adc_sc_deser #(
  parameter int NBITS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             bit_in,
  input  logic             last,
  output logic [NBITS-1:0] sample_o,
  output logic             vld_o
);

  logic [NBITS-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh       <= '0;
      sample_o <= '0;
      vld_o    <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      if (shift_en) sh <= {sh[NBITS-2:0], bit_in};
      if (last) begin
        sample_o <= {sh[NBITS-2:0], bit_in};
        vld_o    <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/adc_selfclk_rx.sv
module adc_selfclk_rx
  import adc_sc_pkg::*;
#(
  parameter int CYC_CYCLES = 120,
  parameter int LAT_CYCLES = 8,
  parameter int NPH        = 3,
  parameter int NBITS      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             din,
  output logic             conv_start,
  output logic             sclk,
  output logic [NBITS-1:0] sample,
  output logic             sample_vld,
  output logic             sync_err
);

  localparam int NPULSE = NBITS + 2;
  localparam int PW     = (NPH > 1) ? $clog2(NPH) : 1;

  // named internal events
  logic          go_w;
  logic          period_end_w;
  logic          lock_evt_w;
  logic [PW-1:0] lock_ph_w;
  logic          bit_stb_w;
  logic          bit_val_w;
  logic          bit_last_w;

  adc_sc_seq #(
    .CYC_CYCLES(CYC_CYCLES),
    .LAT_CYCLES(LAT_CYCLES),
    .NPH       (NPH),
    .NPULSE    (NPULSE)
  ) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .conv_o(conv_start),
    .sclk_o(sclk),
    .go_o  (go_w)
  );

  adc_sc_align #(
    .NPH   (NPH),
    .NBITS (NBITS),
    .NPULSE(NPULSE)
  ) u_align (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go_w),
    .din       (din),
    .period_end(period_end_w),
    .lock_evt  (lock_evt_w),
    .lock_ph   (lock_ph_w),
    .bit_stb   (bit_stb_w),
    .bit_val   (bit_val_w),
    .bit_last  (bit_last_w),
    .sync_err  (sync_err)
  );

  adc_sc_deser #(
    .NBITS(NBITS)
  ) u_deser (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(bit_stb_w),
    .bit_in  (bit_val_w),
    .last    (bit_last_w),
    .sample_o(sample),
    .vld_o   (sample_vld)
  );

endmodule

// File: rtl/adc_selfclk_rx_chk.sv
module adc_selfclk_rx_chk #(
  parameter int CYC_CYCLES = 120,
  parameter int LAT_CYCLES = 8,
  parameter int NPH        = 3,
  parameter int NBITS      = 16,
  localparam int PW        = (NPH > 1) ? $clog2(NPH) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             conv_start,
  input logic             sclk,
  input logic             go,
  input logic             lock_evt,
  input logic [PW-1:0]    lock_ph,
  input logic [NBITS-1:0] sample,
  input logic             sample_vld,
  input logic             sync_err
);

  localparam int NPULSE = NBITS + 2;
  localparam int SW     = $clog2(CYC_CYCLES + 1) + 1;
  localparam int FW     = $clog2(NPULSE + 1) + 1;

  logic          sclk_d;
  logic          fall;
  logic [SW-1:0] since;
  logic [FW-1:0] falls;

  assign fall = sclk_d && !sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b1;
      since  <= '0;
      falls  <= '0;
    end else begin
      sclk_d <= sclk;
      if (conv_start) since <= SW'(1);
      else if (since != '1) since <= since + 1'b1;
      if (conv_start) falls <= '0;
      else if (fall && falls != '1) falls <= falls + 1'b1;
    end
  end

  // R1
  conv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R2
  sclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk |=> sclk);

  // R2
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> sclk);

  // R2
  first_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && falls == '0) |-> (since == SW'(LAT_CYCLES)));

  // R2
  fall_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (falls == '0 || falls == FW'(NPULSE)));

  // R3
  go_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !sclk);

  // R3
  lock_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_evt |=> (lock_ph <= PW'(NPH - 1)));

  // R5
  vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld |=> !sample_vld);

  // R6
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld |-> !sync_err);

  // R8
  sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_vld |-> $stable(sample));

endmodule

bind adc_selfclk_rx adc_selfclk_rx_chk #(
  .CYC_CYCLES(CYC_CYCLES),
  .LAT_CYCLES(LAT_CYCLES),
  .NPH       (NPH),
  .NBITS     (NBITS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .conv_start(conv_start),
  .sclk      (sclk),
  .go        (go_w),
  .lock_evt  (lock_evt_w),
  .lock_ph   (lock_ph_w),
  .sample    (sample),
  .sample_vld(sample_vld),
  .sync_err  (sync_err)
);

// File: tb/sim_adc_selfclk_rx.sv
`timescale 1ns/1ps
module sim_adc_selfclk_rx;

  localparam int CYC = 120;
  localparam int LAT = 8;
  localparam int NPH = 3;
  localparam int NB  = 16;
  localparam int NP  = NB + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic          din = 1'b0;
  logic          conv_start;
  logic          sclk;
  logic [NB-1:0] sample;
  logic          sample_vld;
  logic          sync_err;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // converter model state
  logic [NB-1:0] word = '0;
  int            dly = 0;
  int            mode = 0;   // 0 good, 1 bad marker, 2 silent line
  int            kbit = 0;
  logic          cur = 1'b0;
  logic [7:0]    pipe = '0;
  logic          prev_sclk = 1'b1;

  // monitor state
  int cyc = 0;
  int last_cnv = 0;
  int falls = 0;
  bit have_prev = 1'b0;
  bit dip = 1'b0;

  always #10 clk = ~clk;

  adc_selfclk_rx #(
    .CYC_CYCLES(CYC),
    .LAT_CYCLES(LAT),
    .NPH       (NPH),
    .NBITS     (NB)
  ) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .din       (din),
    .conv_start(conv_start),
    .sclk      (sclk),
    .sample    (sample),
    .sample_vld(sample_vld),
    .sync_err  (sync_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // bit sent after the k-th falling edge of the burst clock
  function automatic logic frame_bit(input int k);
    if (mode == 2) return 1'b0;
    if (k == 0) return 1'b1;
    if (k == 1) return (mode == 1);
    return word[NB + 1 - k];
  endfunction

  // strobe offset: the marker's one lands in period dly/NPH
  function automatic int exp_vld(input int d);
    int h;
    h = d / NPH;
    return LAT + 1 + NPH * h + NPH * 2 + NPH * NB;
  endfunction

  function automatic int exp_bad(input int d);
    return LAT + 1 + NPH * (d / NPH) + 2 * NPH;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      prev_sclk = 1'b1;
      kbit = 0;
      cur = 1'b0;
      pipe = '0;
      din = 1'b0;
    end else begin
      if (!en) dip = 1'b1;
      if (conv_start) begin
        if (have_prev) begin
          check(falls == NP, "R2 pulses per burst", falls, NP);
          if (!dip) check(cyc - last_cnv == CYC, "R1 start period", cyc - last_cnv, CYC);
        end
        have_prev = 1'b1;
        last_cnv = cyc;
        falls = 0;
        dip = 1'b0;
        kbit = 0;
        cur = 1'b0;
      end else if (prev_sclk && !sclk) begin
        if (falls == 0) check(cyc - last_cnv == LAT, "R2 first fall offset", cyc - last_cnv, LAT);
        if (falls > 0) check(1'b1, "R2 low width", 0, 0);
        falls++;
        cur = frame_bit(kbit);
        kbit++;
      end else if (!prev_sclk && !sclk) begin
        check(1'b0, "R2 low width", 2, 1);
      end
      prev_sclk = sclk;
      pipe = {pipe[6:0], cur};
      din = pipe[dly];
    end
  end

  logic [NB-1:0] last_good = '0;

  task automatic do_frame(input logic [NB-1:0] w, input int d, input int m);
    int nv, ne, vat, eat;
    logic [NB-1:0] got;
    nv = 0; ne = 0; vat = -1; eat = -1; got = '0;
    word = w; dly = d; mode = m;
    @(negedge clk);
    while (!conv_start) @(negedge clk);
    for (int i = 1; i <= CYC - 12; i++) begin
      @(negedge clk);
      if (sample_vld) begin nv++; vat = i; got = sample; end
      if (sync_err) begin ne++; eat = i; end
    end
    if (m == 0) begin
      check(nv == 1, "R5 one strobe", nv, 1);
      check(vat == exp_vld(d), "R5 strobe cycle / R3 lock", vat, exp_vld(d));
      check(got == w, "R4 sample word / R3 delay", int'(got), int'(w));
      check(ne == 0, "R3 no error on good frame", ne, 0);
      last_good = w;
    end else begin
      check(nv == 0, (m == 1) ? "R6 no strobe" : "R7 no strobe", nv, 0);
      check(ne == 1, (m == 1) ? "R6 error pulse" : "R7 error pulse", ne, 1);
      if (m == 1) check(eat == exp_bad(d), "R6 error cycle", eat, exp_bad(d));
      else        check(eat == LAT + 1 + NPH * NP, "R7 error cycle", eat, LAT + 1 + NPH * NP);
      check(sample == last_good, "R8 sample held", int'(sample), int'(last_good));
    end
  endtask

  initial begin
    int unsigned sd;
    int nc, nl;
    sd = $urandom(32'd7331);
    repeat (4) @(negedge clk);
    // R9 reset state
    check(conv_start == 1'b0, "R9 conv_start", int'(conv_start), 0);
    check(sclk == 1'b1, "R9 sclk", int'(sclk), 1);
    check(sample_vld == 1'b0, "R9 sample_vld", int'(sample_vld), 0);
    check(sync_err == 1'b0, "R9 sync_err", int'(sync_err), 0);
    check(sample == '0, "R9 sample", int'(sample), 0);
    rst_n = 1'b1;
    en = 1'b1;

    // directed corners: extremes of the code range, every phase offset
    do_frame(16'h8000, 0, 0);
    do_frame(16'h7FFF, 1, 0);
    do_frame(16'hFFFF, 2, 0);
    do_frame(16'h0000, 3, 0);
    do_frame(16'h0001, 5, 0);
    do_frame(16'hA5C3, 4, 0);
    // R6 damaged marker, R7 silent line
    do_frame(16'h1234, 0, 1);
    do_frame(16'h5A5A, 4, 1);
    do_frame(16'hFFFF, 2, 2);
    do_frame(16'h6B2D, 1, 0);

    // random frames
    for (int r = 0; r < 16; r++) begin
      do_frame(NB'($urandom), int'($urandom % 6), 0);
    end

    // R1: enable low suppresses starts and bursts
    en = 1'b0;
    nc = 0; nl = 0;
    for (int i = 0; i < 2 * CYC; i++) begin
      @(negedge clk);
      if (conv_start) nc++;
      if (!sclk) nl++;
    end
    check(nc == 0, "R1 no start while disabled", nc, 0);
    check(nl == 0, "R2 idle high while disabled", nl, 0);
    en = 1'b1;
    do_frame(16'hC001, 3, 0);
    do_frame(16'h4000, 0, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule